// File: doc/BRIEF.md
# Mode-Selectable SPI Serial Engine

This block moves one byte at a time over a four-wire serial link (clock, data in, data out, active-low select). It runs as either a link master or a link slave. The role is picked by a three-bit mode field in the first control register. As a master, the byte starts moving when software writes the data register. The serial clock then comes from one of five sources: a system-clock divider of 4, 16 or 64, a one-cycle time-base tick, or a timer-match strobe whose rate is halved. As a slave, an outside master supplies the serial clock and the select line. Both are brought into the system clock domain through two-flop synchronisers, and their edges are found after synchronisation.

Each finished byte sets a done flag. In slave mode the block also spots a select line that is released partway through a byte. It reports this as an incomplete transfer and sets the done flag as well. The interrupt request follows the done flag when the interrupt is enabled. The two-wire encoding and the off encoding of the mode field both leave the engine idle, the same as clearing the enable bit.

Top module: `spi_engine`

## Requirements
- R1: After reset, address 0 reads 0xE0 (mode field = 7), address 1 reads 0x00, address 2 reads 0x00, and `sckOe`, `sdoOe`, `sckOut`, `irq` are 0.
- R2: Address 0 holds the mode in bits 7:5, enable in bit 1 and the incomplete flag in bit 0; bits 4:2 always read 0. Address 1 holds the done flag in bit 0, interrupt enable in bit 1 and select-sense enable in bit 2; bits 7:3 read 0. Address 2 is the data register; a read returns the last received byte.
- R3: In modes 0 to 4 with enable set, a write to address 2 while idle shifts that byte out on `sdo` MSB first. `sdo` changes after each falling `sckOut` edge, and `sdi` is sampled on each rising edge. After the eighth bit the received byte is readable at address 2 and the done flag is set.
- R4: In modes 0, 1 and 2 the `sckOut` period is 4, 16 and 64 system clocks.
- R5: In mode 3, `sckOut` rises on the clock after each `tbTick` pulse and falls one clock later, so its period equals the tick spacing.
- R6: In mode 4, `sckOut` toggles on each `tmrMatch` strobe, so its period is twice the strobe spacing.
- R7: A write to address 2 while a master transfer is running is ignored; the byte in flight and its result are unchanged.
- R8: With enable 0, or with mode 6 or 7, `sckOe` and `sdoOe` stay 0, `sckOut` stays low, and a data write starts nothing (done stays 0).
- R9: Clearing and then setting enable leaves the mode field and the address 1 settings at their earlier values.
- R10: In mode 5 the engine shifts a byte in on `sdi` from the synchronised rising `sckIn` edges while `scsN` is low. Meanwhile it shifts the byte last written to address 2 out on `sdo`, MSB first, advancing after each falling edge. After eight bits the done flag is set and address 2 returns the received byte.
- R11: In mode 5 with enable and select-sense set, `scsN` going high after at least one clock edge of a byte but before its eighth bit sets both the incomplete flag and the done flag. Address 2 keeps its previous value.
- R12: A software write of 1 to the incomplete flag sets only that flag, not the done flag. Outside mode 5 the incomplete flag changes only through software writes.
- R13: `irq` is high exactly when the done flag and interrupt enable are both set; writing 0 to the done flag clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register address (0 control, 1 status/options, 2 data) |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` |
| tbTick | input | 1 | Time-base tick, one clock wide |
| tmrMatch | input | 1 | Timer-match strobe, one clock wide |
| sckIn | input | 1 | Serial clock from an outside master (slave mode) |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckOe | output | 1 | Output enable for `sckOut` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for `sdo` |
| scsN | input | 1 | Active-low select from an outside master |
| irq | output | 1 | Interrupt request |

## Verification
Master transfers run in every clock mode, each with random data. Between the directed and random runs, the looped-back data path is both straight and inverted, which separates a correct MSB-first shift from a reversed bit order or a stuck data line. Measuring the `sckOut` period in every mode shows a wrong divider limit or a wrong edge count in the tick and timer modes. Slave bytes are sent whole and also cut off after three bits, which separates the completion path from the incomplete path. The last group covers the off states, a write while a transfer is running, and a software write to the incomplete flag; each shows whether a stimulus that should have no effect really has none.

// File: rtl/spi_engine_pkg.sv
package spi_engine_pkg;

  typedef enum logic [2:0] {
    MD_DIV4    = 3'd0,
    MD_DIV16   = 3'd1,
    MD_DIV64   = 3'd2,
    MD_TBASE   = 3'd3,
    MD_TMATCH  = 3'd4,
    MD_SLAVE   = 3'd5,
    MD_TWOWIRE = 3'd6,
    MD_OFF     = 3'd7
  } spiMode_t;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic commit;
  } spiStrb_t;

  localparam logic [1:0] ADDR_CTL0 = 2'd0;
  localparam logic [1:0] ADDR_CTL1 = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/spi_dpath.sv
module spi_dpath
  import spi_engine_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrb_t          strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sdiBit,
  output logic              txBit,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0] shiftReg;
  logic              rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBit    <= 1'b0;
      rxByte   <= '0;
    end else begin
      if (strb.sample) rxBit <= sdiBit;
      if (strb.load) begin
        shiftReg <= wdata;
      end else if (strb.shift) begin
        shiftReg <= {shiftReg[DATA_W-2:0], rxBit};
      end
      if (strb.commit) rxByte <= {shiftReg[DATA_W-2:0], rxBit};
    end
  end

  assign txBit = shiftReg[DATA_W-1];

  // R3
  load_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (txBit == $past(wdata[DATA_W-1])));

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(rxByte));

endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_engine_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic [2:0] wrMode,
  input  logic [2:0] wrLow,
  input  logic       tbTick,
  input  logic       tmrMatch,
  input  logic       sckIn,
  input  logic       scsN,
  output spiStrb_t   strb,
  output logic [7:0] ctl0Rd,
  output logic [7:0] ctl1Rd,
  output logic       sckOut,
  output logic       sckOe,
  output logic       sdoOe,
  output logic       irq
);

  localparam int DIV_W = $clog2(DIV_C / 2);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [DIV_W-1:0] LIM_A = DIV_W'(DIV_A / 2 - 1);
  localparam logic [DIV_W-1:0] LIM_B = DIV_W'(DIV_B / 2 - 1);
  localparam logic [DIV_W-1:0] LIM_C = DIV_W'(DIV_C / 2 - 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  spiMode_t          mode;
  logic              en, incFlag, doneFlag, irqEn, csEn;
  logic              busy, sckInt, started;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [SYNC_N-1:0] sckS, scsS;
  logic              sckD, scsD;

  logic masterOn, slaveOn, selected, halfTick, lastBit;
  logic sckRise, sckFall, scsRise, incEvent;
  logic ctl0Wr, ctl1Wr, dataWr, startReq;

  assign masterOn = en && (mode <= MD_TMATCH);
  assign slaveOn  = en && (mode == MD_SLAVE);
  assign ctl0Wr   = regWr && (regAddr == ADDR_CTL0);
  assign ctl1Wr   = regWr && (regAddr == ADDR_CTL1);
  assign dataWr   = regWr && (regAddr == ADDR_DATA);
  assign startReq = masterOn && dataWr && !busy;
  assign lastBit  = (bitCnt == LAST);

  assign sckRise  = sckS[SYNC_N-1] && !sckD;
  assign sckFall  = !sckS[SYNC_N-1] && sckD;
  assign scsRise  = scsS[SYNC_N-1] && !scsD;
  assign selected = csEn ? !scsS[SYNC_N-1] : 1'b1;
  assign incEvent = slaveOn && csEn && scsRise && (started || (bitCnt != '0));

  always_comb begin
    case (mode)
      MD_DIV4:   halfTick = (divCnt == LIM_A);
      MD_DIV16:  halfTick = (divCnt == LIM_B);
      MD_DIV64:  halfTick = (divCnt == LIM_C);
      MD_TBASE:  halfTick = sckInt || tbTick;
      MD_TMATCH: halfTick = tmrMatch;
      default:   halfTick = 1'b0;
    endcase
  end

  always_comb begin
    strb.load   = startReq ||
                  (slaveOn && dataWr && !started && (bitCnt == '0));
    strb.sample = (masterOn && busy && halfTick && !sckInt) ||
                  (slaveOn && selected && sckRise);
    strb.shift  = (masterOn && busy && halfTick && sckInt) ||
                  (slaveOn && selected && sckFall);
    strb.commit = strb.shift && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MD_OFF;
      {en, incFlag, doneFlag, irqEn, csEn} <= '0;
      {busy, sckInt, started} <= '0;
      divCnt <= '0;
      bitCnt <= '0;
      sckS   <= '0;
      scsS   <= '1;
      sckD   <= 1'b0;
      scsD   <= 1'b1;
    end else begin
      if (ctl0Wr) begin
        mode    <= spiMode_t'(wrMode);
        en      <= wrLow[1];
        incFlag <= wrLow[0];
      end
      if (ctl1Wr) begin
        doneFlag <= wrLow[0];
        irqEn    <= wrLow[1];
        csEn     <= wrLow[2];
      end
      sckS <= {sckS[SYNC_N-2:0], sckIn};
      scsS <= {scsS[SYNC_N-2:0], scsN};
      sckD <= sckS[SYNC_N-1];
      scsD <= scsS[SYNC_N-1];

      if (masterOn) begin
        started <= 1'b0;
        if (startReq) begin
          busy   <= 1'b1;
          sckInt <= 1'b0;
          divCnt <= '0;
          bitCnt <= '0;
        end else if (busy) begin
          if (halfTick) begin
            divCnt <= '0;
            sckInt <= !sckInt;
            if (sckInt) begin
              bitCnt <= bitCnt + 1'b1;
              if (lastBit) begin
                busy     <= 1'b0;
                doneFlag <= 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      end else if (slaveOn) begin
        busy   <= 1'b0;
        sckInt <= 1'b0;
        if (!selected) begin
          bitCnt  <= '0;
          started <= 1'b0;
        end else begin
          if (sckRise) started <= 1'b1;
          if (sckFall) begin
            bitCnt <= bitCnt + 1'b1;
            if (lastBit) begin
              bitCnt   <= '0;
              started  <= 1'b0;
              doneFlag <= 1'b1;
            end
          end
        end
        if (incEvent) begin
          incFlag  <= 1'b1;
          doneFlag <= 1'b1;
        end
      end else begin
        {busy, sckInt, started} <= '0;
        divCnt <= '0;
        bitCnt <= '0;
      end
    end
  end

  assign ctl0Rd = {mode, 3'b000, en, incFlag};
  assign ctl1Rd = {5'b00000, csEn, irqEn, doneFlag};
  assign sckOut = masterOn && sckInt;
  assign sckOe  = masterOn;
  assign sdoOe  = masterOn || (slaveOn && selected);
  assign irq    = irqEn && doneFlag;

  // R12
  inc_only_slave_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!incFlag && !ctl0Wr && (mode != MD_SLAVE)) |=> !incFlag);

  // R11
  inc_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    incEvent |=> (incFlag && doneFlag));

  // R8
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !busy);

  // R3
  sck_low_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckInt);

endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_engine_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       tbTick,
  input  logic       tmrMatch,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdoOe,
  input  logic       scsN,
  output logic       irq
);

  spiStrb_t          strb;
  logic [7:0]        ctl0Rd, ctl1Rd;
  logic              txBit;
  logic [DATA_W-1:0] rxByte;

  spi_ctrl #(
    .DATA_W(DATA_W), .DIV_A(DIV_A), .DIV_B(DIV_B),
    .DIV_C(DIV_C), .SYNC_N(SYNC_N)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .wrMode(regWdata[7:5]), .wrLow(regWdata[2:0]),
    .tbTick(tbTick), .tmrMatch(tmrMatch), .sckIn(sckIn), .scsN(scsN),
    .strb(strb), .ctl0Rd(ctl0Rd), .ctl1Rd(ctl1Rd),
    .sckOut(sckOut), .sckOe(sckOe), .sdoOe(sdoOe), .irq(irq)
  );

  spi_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wdata(regWdata[DATA_W-1:0]), .sdiBit(sdi),
    .txBit(txBit), .rxByte(rxByte)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTL0: regRdata = ctl0Rd;
      ADDR_CTL1: regRdata = ctl1Rd;
      ADDR_DATA: regRdata = 8'(rxByte);
      default:   regRdata = 8'h00;
    endcase
  end

  assign sdo = sdoOe && txBit;

endmodule

// File: tb/spi_engine_tb.sv
module spi_engine_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       tbTick = 1'b0, tmrMatch = 1'b0;
  logic       sckIn = 1'b0, scsN = 1'b1;
  logic       sckOut, sckOe, sdo, sdoOe, irq, sdi;
  logic       slaveDrive = 1'b0, benchSdi = 1'b0, loopInv = 1'b0;

  int testCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  assign sdi = slaveDrive ? benchSdi : (sdo ^ loopInv);

  spi_engine u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .tbTick(tbTick),
    .tmrMatch(tmrMatch), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe), .scsN(scsN), .irq(irq)
  );

  function automatic int expPeriod(input logic [2:0] md, input int gap);
    case (md)
      3'd0: return 4;
      3'd1: return 16;
      3'd2: return 64;
      3'd3: return gap;
      default: return 2 * gap;
    endcase
  endfunction

  function automatic logic [7:0] expRx(input logic [7:0] tx, input logic inv);
    return inv ? ~tx : tx;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic masterXfer(input logic [2:0] md, input logic [7:0] tx,
                            input int gap, input logic inv,
                            output int period, output int rises);
    int lastRise, prevRise;
    logic prevSck;
    loopInv = inv;
    regWrite(2'd0, {md, 3'b000, 1'b1, 1'b0});
    regWrite(2'd2, tx);
    regAddr = 2'd1;
    lastRise = -1; prevRise = -1; rises = 0; prevSck = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      tbTick   = (md == 3'd3) && (cyc % gap == 0);
      tmrMatch = (md == 3'd4) && (cyc % gap == 0);
      @(negedge clk);
      if (sckOut && !prevSck) begin
        rises++; prevRise = lastRise; lastRise = cyc;
      end
      prevSck = sckOut;
      if (regRdata[0]) break;
    end
    tbTick = 1'b0; tmrMatch = 1'b0;
    period = lastRise - prevRise;
  endtask

  task automatic slaveXfer(input logic [7:0] tx, input int nbits,
                           output logic [7:0] seen, output int oeOk);
    seen = '0; oeOk = 1;
    slaveDrive = 1'b1;
    @(negedge clk); scsN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      benchSdi = tx[7-i];
      repeat (8) @(negedge clk);
      seen[7-i] = sdo;
      if (!sdoOe) oeOk = 0;
      sckIn = 1'b1;
      repeat (8) @(negedge clk);
      sckIn = 1'b0;
      repeat (8) @(negedge clk);
    end
    scsN = 1'b1;
    repeat (8) @(negedge clk);
    slaveDrive = 1'b0;
  endtask

  initial begin
    #400000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [7:0] rd, seen, tx;
    logic [2:0] md;
    logic inv;
    int period, rises, gap, oeOk, sawSck;
    void'($urandom(32'h5EED1234));

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd0, rd); chk("R1 ctl0", rd, 8'hE0);
    regRead(2'd1, rd); chk("R1 ctl1", rd, 8'h00);
    regRead(2'd2, rd); chk("R1 data", rd, 8'h00);
    chk("R1 outputs", {sckOe, sdoOe, sckOut, irq}, 0);

    // R2 / R12: reserved bits read 0; software-set incomplete leaves done clear
    regWrite(2'd1, 8'hFA);
    regRead(2'd1, rd); chk("R2 ctl1 layout", rd, 8'h02);
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'hFF);
    regRead(2'd0, rd); chk("R2 ctl0 layout", rd, 8'hE3);
    regRead(2'd1, rd); chk("R12 sw inc no done", rd, 8'h00);
    chk("R12 no irq", irq, 0);
    regWrite(2'd0, 8'h00);
    regRead(2'd0, rd); chk("R2 ctl0 clear", rd, 8'h00);

    // R8: disabled, then two-wire and off encodings with enable set
    for (int k = 0; k < 3; k++) begin
      regWrite(2'd0, (k == 0) ? 8'h00 : ((k == 1) ? 8'hC2 : 8'hE2));
      regWrite(2'd2, 8'h5A);
      sawSck = 0;
      for (int c = 0; c < 100; c++) begin
        @(negedge clk);
        if (sckOut || sckOe || sdoOe) sawSck = 1;
      end
      chk("R8 no activity", sawSck, 0);
      regRead(2'd1, rd); chk("R8 no done", rd[0], 0);
    end

    // R3/R4/R5/R6/R13 directed master transfers
    regWrite(2'd1, 8'h02);
    for (int k = 0; k < 5; k++) begin
      md  = 3'(k);
      tx  = (k == 0) ? 8'hA5 : (k == 1) ? 8'h3C : (k == 2) ? 8'h81 :
            (k == 3) ? 8'h7E : 8'h12;
      inv = k[0];
      gap = (k == 3) ? 5 : 3;
      masterXfer(md, tx, gap, inv, period, rises);
      chk("R4 R5 R6 sck period", period, expPeriod(md, gap));
      chk("R3 eight clocks", rises, 8);
      regRead(2'd2, rd); chk("R3 master rx byte", rd, expRx(tx, inv));
      chk("R13 irq on done", irq, 1);
      regWrite(2'd1, 8'h02);
      @(negedge clk); chk("R13 irq cleared", irq, 0);
    end

    // R3/R4/R5/R6 random master transfers
    for (int k = 0; k < 10; k++) begin
      md  = 3'($urandom_range(0, 4));
      tx  = 8'($urandom);
      inv = 1'($urandom_range(0, 1));
      gap = $urandom_range(3, 7);
      masterXfer(md, tx, gap, inv, period, rises);
      chk("R4 R5 R6 random period", period, expPeriod(md, gap));
      regRead(2'd2, rd); chk("R3 random rx byte", rd, expRx(tx, inv));
      regRead(2'd1, rd); chk("R3 random done", rd[0], 1);
      regWrite(2'd1, 8'h00);
    end

    // R7: second write while busy is ignored
    loopInv = 1'b0;
    regWrite(2'd0, 8'h22);
    regWrite(2'd2, 8'hC6);
    regWrite(2'd2, 8'h19);
    regAddr = 2'd1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (regRdata[0]) break;
    end
    regRead(2'd2, rd); chk("R7 busy write ignored", rd, 8'hC6);
    regWrite(2'd1, 8'h00);

    // R9: settings survive enable toggle
    regWrite(2'd1, 8'h06);
    regWrite(2'd0, 8'hA0);
    regWrite(2'd0, 8'hA2);
    regRead(2'd1, rd); chk("R9 ctl1 kept", rd, 8'h06);
    regRead(2'd0, rd); chk("R9 ctl0 kept", rd, 8'hA2);

    // R10: full slave byte
    regWrite(2'd2, 8'hC3);
    slaveXfer(8'h96, 8, seen, oeOk);
    regRead(2'd2, rd); chk("R10 slave rx", rd, 8'h96);
    chk("R10 slave tx", seen, 8'hC3);
    chk("R10 sdo enabled", oeOk, 1);
    regRead(2'd1, rd); chk("R10 done", rd[0], 1);
    regRead(2'd0, rd); chk("R11 no inc on full", rd[0], 0);
    regWrite(2'd1, 8'h06);

    // R11: select released mid-byte
    regWrite(2'd2, 8'h55);
    slaveXfer(8'h0F, 3, seen, oeOk);
    regRead(2'd0, rd); chk("R11 inc flag", rd[0], 1);
    regRead(2'd1, rd); chk("R11 done flag", rd[0], 1);
    chk("R13 irq on inc", irq, 1);
    regRead(2'd2, rd); chk("R11 rx unchanged", rd, 8'h96);
    chk("R10 partial tx bits", seen[7:5], 3'b010);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule